// File: doc/BRIEF.md
# Level-Handshake Word Transfer Between Clock Domains

This block carries one data word at a time from a source clock domain to a destination clock domain that has no known phase or frequency relation to it. Only two single-bit levels cross the boundary: a request that travels forward and an acknowledge that travels back. Each passes through a parameterized chain of flip-flops clocked by the domain that receives it. The word itself crosses on a plain bus with no synchronizer. The source latches the word and keeps it frozen for the whole exchange, so the bus is settled long before the destination samples it.

A transfer is a four-phase exchange. The source raises the request. The destination sees it, captures the bus, pulses its valid output for one cycle and raises the acknowledge. The source sees the acknowledge and drops the request. The destination sees the request fall and drops the acknowledge. When the source sees the acknowledge low again, it is free for the next word.

The source interface is a one-cycle send strobe qualified by a busy output. Busy acts as the inverse of a ready signal. While busy is high the source cannot take a new word, and a strobe in that state is discarded and reported on an error output. Nothing is queued. The destination interface is a valid pulse with its word and has no back-pressure: the consumer must take the word in the cycle valid is high. The word stays on the output until the next delivery.

Top module: `cdc_handshake_bridge`

## Requirements
- R1: While either reset is low, and after both are released before any send, src_busy, src_err and dst_valid are 0 and dst_data is all zeros.
- R2: A src_send seen on a source clock edge with src_busy low is accepted: the word on src_data is latched at that edge and src_busy reads 1 from that edge on.
- R3: Each accepted word appears on dst_data together with a dst_valid pulse that lasts exactly one destination clock cycle.
- R4: The delivered word equals src_data at the accepting edge, whatever src_data does afterwards.
- R5: A src_send seen on a source edge while src_busy is 1 is discarded. It changes neither the word in flight nor src_busy, and src_err reads 1 for exactly the one source cycle after that edge.
- R6: src_busy stays 1 until the returning acknowledge, after its synchronizer, is seen low once more. The next source cycle then accepts a new send.
- R7: Exactly one dst_valid pulse is produced for each accepted send.
- R8: STAGES sets the flip-flop count of both synchronizer chains, so one exchange keeps src_busy high for at least 2*STAGES source cycles.
- R9: dst_data changes only in a cycle where dst_valid is 1.
- R10: The latched source word, which drives the unsynchronized bus, stays constant for as long as the request level is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_s | input | 1 | Source domain clock |
| rst_s_n | input | 1 | Source domain asynchronous reset, active low |
| src_send | input | 1 | One-cycle strobe offering src_data |
| src_data | input | WIDTH | Word offered with the strobe |
| src_busy | output | 1 | Exchange in progress; strobes are not accepted |
| src_err | output | 1 | One-cycle flag: a strobe arrived while busy |
| clk_d | input | 1 | Destination domain clock |
| rst_d_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_valid | output | 1 | One-cycle pulse marking a delivered word |
| dst_data | output | WIDTH | Last delivered word |

## Verification
The bench builds the block with STAGES = 3 and WIDTH = 12. Three-stage chains lengthen every leg of the exchange. This opens wide windows in which strobes land during the request phase and during the drain phase. It also makes the minimum busy time of R8 a non-trivial bound. The two clocks run at 4 ns and 7 ns with an offset so that their edges never coincide, which gives a behavioural model that steps each domain on its own edge a well-defined view of the other domain.

// File: rtl/cdc_hs_pkg.sv
package cdc_hs_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE  = 2'd0,
    SRC_ASK   = 2'd1,
    SRC_DRAIN = 2'd2
  } src_state_e;

  typedef enum logic {
    DST_WAIT = 1'b0,
    DST_HELD = 1'b1
  } dst_state_e;
endpackage

// File: rtl/cdc_hs_sync.sv
module cdc_hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain;

  generate
    for (genvar i = 0; i < N; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[N-1];
endmodule

// File: rtl/cdc_hs_src.sv
module cdc_hs_src
  import cdc_hs_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             send,
  input  logic [WIDTH-1:0] data,
  input  logic             ack_seen,
  output logic             req,
  output logic [WIDTH-1:0] hold,
  output logic             busy,
  output logic             err
);
  src_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SRC_IDLE;
      req   <= 1'b0;
      hold  <= '0;
      err   <= 1'b0;
    end else begin
      err <= send && (state != SRC_IDLE);
      unique case (state)
        SRC_IDLE: begin
          if (send) begin
            hold  <= data;
            req   <= 1'b1;
            state <= SRC_ASK;
          end
        end
        SRC_ASK: begin
          if (ack_seen) begin
            req   <= 1'b0;
            state <= SRC_DRAIN;
          end
        end
        SRC_DRAIN: begin
          if (!ack_seen) state <= SRC_IDLE;
        end
        default: state <= SRC_IDLE;
      endcase
    end
  end

  assign busy = (state != SRC_IDLE);
endmodule

// File: rtl/cdc_hs_dst.sv
module cdc_hs_dst
  import cdc_hs_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_seen,
  input  logic [WIDTH-1:0] bus,
  output logic             ack,
  output logic             valid,
  output logic [WIDTH-1:0] word
);
  dst_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= DST_WAIT;
      ack   <= 1'b0;
      valid <= 1'b0;
      word  <= '0;
    end else begin
      valid <= 1'b0;
      unique case (state)
        DST_WAIT: begin
          if (req_seen) begin
            word  <= bus;
            valid <= 1'b1;
            ack   <= 1'b1;
            state <= DST_HELD;
          end
        end
        DST_HELD: begin
          if (!req_seen) begin
            ack   <= 1'b0;
            state <= DST_WAIT;
          end
        end
        default: state <= DST_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/cdc_handshake_bridge.sv
module cdc_handshake_bridge #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_s,
  input  logic             rst_s_n,
  input  logic             src_send,
  input  logic [WIDTH-1:0] src_data,
  output logic             src_busy,
  output logic             src_err,
  input  logic             clk_d,
  input  logic             rst_d_n,
  output logic             dst_valid,
  output logic [WIDTH-1:0] dst_data
);
  logic             req_lvl;
  logic             ack_lvl;
  logic             req_at_dst;
  logic             ack_at_src;
  logic [WIDTH-1:0] hold_word;

  cdc_hs_src #(.WIDTH(WIDTH)) u_src (
    .clk      (clk_s),
    .rst_n    (rst_s_n),
    .send     (src_send),
    .data     (src_data),
    .ack_seen (ack_at_src),
    .req      (req_lvl),
    .hold     (hold_word),
    .busy     (src_busy),
    .err      (src_err)
  );

  cdc_hs_sync #(.STAGES(STAGES)) u_req_sync (
    .clk   (clk_d),
    .rst_n (rst_d_n),
    .d     (req_lvl),
    .q     (req_at_dst)
  );

  cdc_hs_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk   (clk_s),
    .rst_n (rst_s_n),
    .d     (ack_lvl),
    .q     (ack_at_src)
  );

  cdc_hs_dst #(.WIDTH(WIDTH)) u_dst (
    .clk      (clk_d),
    .rst_n    (rst_d_n),
    .req_seen (req_at_dst),
    .bus      (hold_word),
    .ack      (ack_lvl),
    .valid    (dst_valid),
    .word     (dst_data)
  );
endmodule

// File: rtl/cdc_handshake_bridge_chk.sv
module cdc_handshake_bridge_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_s,
  input logic             rst_s_n,
  input logic             busy,
  input logic             err,
  input logic             req,
  input logic [WIDTH-1:0] hold,
  input logic             clk_d,
  input logic             rst_d_n,
  input logic             valid,
  input logic             ack,
  input logic [WIDTH-1:0] dout
);
  // R5
  err_after_busy_chk: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    err |-> $past(busy));

  // R10
  hold_stable_chk: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    (req && $past(req)) |-> $stable(hold));

  // R6
  req_inside_busy_chk: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    req |-> busy);

  // R3
  valid_single_chk: assert property (@(posedge clk_d) disable iff (!rst_d_n)
    valid |=> !valid);

  // R7
  valid_with_ack_chk: assert property (@(posedge clk_d) disable iff (!rst_d_n)
    valid |-> ack);

  // R9
  dout_hold_chk: assert property (@(posedge clk_d) disable iff (!rst_d_n)
    !valid |-> $stable(dout));
endmodule

bind cdc_handshake_bridge cdc_handshake_bridge_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_s   (clk_s),
  .rst_s_n (rst_s_n),
  .busy    (src_busy),
  .err     (src_err),
  .req     (req_lvl),
  .hold    (hold_word),
  .clk_d   (clk_d),
  .rst_d_n (rst_d_n),
  .valid   (dst_valid),
  .ack     (ack_lvl),
  .dout    (dst_data)
);

// File: tb/sim_cdc_handshake_bridge.sv
`timescale 1ns/100ps
module sim_cdc_handshake_bridge;
  localparam int W   = 12;
  localparam int STG = 3;

  logic         clk_s = 1'b0;
  logic         clk_d = 1'b0;
  logic         rst_s_n = 1'b0;
  logic         rst_d_n = 1'b0;
  logic         src_send = 1'b0;
  logic [W-1:0] src_data = '0;
  logic         src_busy, src_err, dst_valid;
  logic [W-1:0] dst_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  cdc_handshake_bridge #(.WIDTH(W), .STAGES(STG)) u0 (
    .clk_s(clk_s), .rst_s_n(rst_s_n), .src_send(src_send), .src_data(src_data),
    .src_busy(src_busy), .src_err(src_err),
    .clk_d(clk_d), .rst_d_n(rst_d_n), .dst_valid(dst_valid), .dst_data(dst_data)
  );

  always #2 clk_s = ~clk_s;
  initial begin
    #1.3;
    forever #3.5 clk_d = ~clk_d;
  end

  // behavioural reference: per-domain state, pipes as arrays
  int           m_sst = 0;
  bit           m_req = 0, m_err = 0;
  logic [W-1:0] m_hold = '0;
  bit           m_ackp [STG];
  int           m_dst = 0;
  bit           m_ack = 0, m_valid = 0;
  logic [W-1:0] m_out = '0;
  bit           m_reqp [STG];
  int           m_accepts = 0;
  int           seen_valids = 0;

  always @(posedge clk_s or negedge rst_s_n) begin
    bit a_seen;
    if (!rst_s_n) begin
      m_sst = 0; m_req = 0; m_err = 0; m_hold = '0;
      for (int i = 0; i < STG; i++) m_ackp[i] = 0;
    end else begin
      a_seen = m_ackp[STG-1];
      for (int i = STG-1; i > 0; i--) m_ackp[i] = m_ackp[i-1];
      m_ackp[0] = m_ack;
      m_err = src_send && (m_sst != 0);
      if (m_sst == 0) begin
        if (src_send) begin
          m_hold = src_data; m_req = 1; m_sst = 1; m_accepts++;
        end
      end else if (m_sst == 1) begin
        if (a_seen) begin m_req = 0; m_sst = 2; end
      end else begin
        if (!a_seen) m_sst = 0;
      end
    end
  end

  always @(posedge clk_d or negedge rst_d_n) begin
    bit r_seen;
    if (!rst_d_n) begin
      m_dst = 0; m_ack = 0; m_valid = 0; m_out = '0;
      for (int i = 0; i < STG; i++) m_reqp[i] = 0;
    end else begin
      r_seen = m_reqp[STG-1];
      for (int i = STG-1; i > 0; i--) m_reqp[i] = m_reqp[i-1];
      m_reqp[0] = m_req;
      m_valid = 0;
      if (m_dst == 0) begin
        if (r_seen) begin m_out = m_hold; m_valid = 1; m_ack = 1; m_dst = 1; end
      end else if (!r_seen) begin
        m_ack = 0; m_dst = 0;
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every source clock
  always @(negedge clk_s) if (rst_s_n && rst_d_n && !done) begin
    chk("R2/R6 busy", src_busy, (m_sst != 0));
    chk("R5 err", src_err, m_err);
  end

  // compare on every destination clock
  always @(negedge clk_d) if (rst_s_n && rst_d_n && !done) begin
    chk("R3 valid", dst_valid, m_valid);
    chk("R4/R9 dst_data", dst_data, m_out);
    if (dst_valid) seen_valids++;
  end

  task automatic send_word(input logic [W-1:0] w);
    @(negedge clk_s);
    src_send = 1'b1;
    src_data = w;
    @(negedge clk_s);
    src_send = 1'b0;
  endtask

  task automatic wait_idle();
    while (src_busy) @(negedge clk_s);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    int busy_len;
    repeat (6) @(negedge clk_s);
    // R1: outputs quiet during reset
    chk("R1 busy in reset", src_busy, 0);
    chk("R1 valid in reset", dst_valid, 0);
    rst_s_n = 1'b1;
    rst_d_n = 1'b1;
    repeat (4) @(negedge clk_s);
    chk("R1 busy after reset", src_busy, 0);
    chk("R1 err after reset", src_err, 0);
    chk("R1 valid after reset", dst_valid, 0);
    chk("R1 data after reset", dst_data, 0);

    // R2/R3: several word patterns, one at a time
    send_word(12'hFFF); wait_idle();
    send_word(12'h5A5); wait_idle();
    send_word(12'hA5A); wait_idle();
    send_word(12'h001); wait_idle();
    chk("R2 idle before next", src_busy, 0);

    // R8: busy duration lower bound
    send_word(12'h3C3);
    busy_len = 0;
    while (src_busy) begin busy_len++; @(negedge clk_s); end
    chk("R8 busy >= 2*STAGES", (busy_len >= 2*STG), 1);

    // R4: input changes right after acceptance
    @(negedge clk_s);
    src_send = 1'b1; src_data = 12'h123;
    @(negedge clk_s);
    src_send = 1'b0; src_data = 12'hEDC;
    repeat (3) @(negedge clk_s);
    src_data = 12'h777;
    wait_idle();
    repeat (2) @(negedge clk_d);
    chk("R4 word from accept edge", dst_data, 12'h123);

    // R5: strobes while busy, in request phase and later in drain phase
    send_word(12'h0F0);
    repeat (1) @(negedge clk_s);
    send_word(12'hBAD);
    chk("R5 err pulse", src_err, 1);
    @(negedge clk_s);
    chk("R5 err single cycle", src_err, 0);
    repeat (10) @(negedge clk_s);
    if (src_busy) send_word(12'hDEF);
    wait_idle();
    repeat (2) @(negedge clk_d);
    chk("R5 ignored word not delivered", dst_data, 12'h0F0);

    // R6: send on the first idle cycle
    send_word(12'h456);
    wait_idle();
    send_word(12'h789);
    wait_idle();
    for (int k = 0; k < 8; k++) begin
      send_word(W'(k * 12'h111 + 12'h00F));
      wait_idle();
    end
    repeat (3 * STG + 4) @(negedge clk_d);

    // R7: one valid per accepted send
    chk("R7 valid count", seen_valids, m_accepts);
    chk("R7 accepted sends", m_accepts, 17);
    finish_run();
  end
endmodule